// File: doc/BRIEF.md
# Operand Width and Mode Controller

This block keeps the execution-mode state of a CPU whose accumulator and index registers can run 8, 16 or 32 bits wide. It stores two hidden tier bits (called here tier16 and tier8) together with the accumulator-size flag M and the index-size flag X. From these four bits it works out the present accumulator/memory width, the index-register width and the number of bytes that follow an opcode carrying an accumulator immediate operand.

It also carries out the exchange instruction, which trades the carry flag with tier8. In the narrow legacy tier only carry is traded. In every other tier, overflow is traded with tier16 as well. The surrounding core drives the current C and V into the block and takes back the exchanged values in the same cycle. Set-bits and reset-bits requests for M and X, and loads of M and X from a pulled status byte, arrive on separate strobes. The tier bits are not part of the status byte, so a status load never changes them.

Top module: `opWidthCtl`

## Requirements
- R1: After reset, tier16, tier8, M and X are all 1. Both width codes are 2'b00, immBytes is 1, legacyMode is 1 and flagM and flagX read 1.
- R2: In the legacy tier (tier16=tier8=1), both widths stay 8 bits. A reset-bits request cannot clear flagM or flagX, and a status load cannot clear them either.
- R3: An exchange in the legacy tier returns cFlagOut=1 (the old tier8) and vFlagOut=vFlagIn. It then loads tier8 from cFlagIn and leaves tier16 at 1. Exchanging with C=0 enters the 16-bit tier.
- R4: An exchange outside the legacy tier returns the old tier8 on cFlagOut and the old tier16 on vFlagOut. It then loads tier8 from cFlagIn and tier16 from vFlagIn.
- R5: With tier16=1 and tier8=0, the accumulator is 16 bits when M=0 and 8 bits when M=1. The index registers are 16 bits when X=0 and 8 bits when X=1.
- R6: With tier16=0 and tier8=0, the accumulator is 16 bits when M=0 and 8 bits when M=1. The index registers are 32 bits when X=0 and 8 bits when X=1.
- R7: With tier16=0 and tier8=1, the accumulator is 32 bits when M=0 and 8 bits when M=1. The index registers are 32 bits when X=0 and 8 bits when X=1.
- R8: Width codes are 2'b00 for 8 bits, 2'b01 for 16 bits and 2'b10 for 32 bits. immBytes is 1, 2 or 4 to follow the accumulator width.
- R9: A status load copies statMx[1] into M and statMx[0] into X and leaves both tier bits unchanged.
- R10: The widths, flagM, flagX and legacyMode change at the clock edge that ends a strobe cycle and stay stable when no strobe is present. Without an exchange, cFlagOut equals cFlagIn and vFlagOut equals vFlagIn.
- R11: An exchange that lands in the legacy tier (C=1 and the resulting tier16=1) forces M and X to 1.
- R12: legacyMode, which marks that the X bit position holds the ignored break flag, is 1 only when tier16 and tier8 are both 1.
- R13: Only one update is applied per cycle, in the priority order exchange, status load, set-bits, reset-bits. In mxMask and statMx, bit 1 selects M and bit 0 selects X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xceStrobe | input | 1 | Exchange instruction executes this cycle |
| cFlagIn | input | 1 | Current carry flag |
| vFlagIn | input | 1 | Current overflow flag |
| sepStrobe | input | 1 | Set the M/X bits selected by mxMask |
| repStrobe | input | 1 | Clear the M/X bits selected by mxMask |
| mxMask | input | 2 | Bit 1 selects M, bit 0 selects X |
| statLoad | input | 1 | Load M/X from a pulled status byte |
| statMx | input | 2 | Pulled M (bit 1) and X (bit 0) values |
| accWidth | output | 2 | Accumulator/memory width code |
| idxWidth | output | 2 | Index-register width code |
| immBytes | output | 3 | Accumulator immediate length in bytes |
| cFlagOut | output | 1 | Carry after exchange |
| vFlagOut | output | 1 | Overflow after exchange |
| flagM | output | 1 | Current M flag |
| flagX | output | 1 | Current X flag (break position in legacy tier) |
| legacyMode | output | 1 | Legacy tier active; X position holds break |

## Verification
The bench walks the block through all four tiers, using exchanges with each useful combination of C and V. At each tier it sweeps M and X, so that every cell of the width table is reached and the tiers that share some codes are told apart by their 16- versus 32-bit entries. In the legacy tier, clearing requests and status loads of zeros show that the forced 8-bit state cannot be escaped except by an exchange. A return to the legacy tier from a tier with M=X=0 shows the forcing on entry. A status load made after reaching the 32-bit tier, followed by a clear, shows that the tier bits survive status loads. Simultaneous set and clear requests confirm the priority order.

// File: rtl/owPkg.sv
package owPkg;
  localparam int CODE_W = 2;
  localparam int IMM_W  = 3;
  localparam logic [CODE_W-1:0] W8  = 2'b00;
  localparam logic [CODE_W-1:0] W16 = 2'b01;
  localparam logic [CODE_W-1:0] W32 = 2'b10;

  typedef struct packed {
    logic xchg;      // trade carry with tier8
    logic xchgV;     // also trade overflow with tier16
    logic loadBits;  // copy pulled M/X
    logic setBits;   // OR mask into M/X
    logic clrBits;   // clear masked M/X
  } owStrobe_t;
endpackage

// File: rtl/owControl.sv
module owControl
  import owPkg::*;
(
  input  logic      xceStrobe,
  input  logic      statLoad,
  input  logic      sepStrobe,
  input  logic      repStrobe,
  input  logic      legacy,
  output owStrobe_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.xchg     = xceStrobe;
    strobes.xchgV    = xceStrobe & ~legacy;
    strobes.loadBits = ~xceStrobe & statLoad;
    strobes.setBits  = ~xceStrobe & ~statLoad & sepStrobe;
    strobes.clrBits  = ~xceStrobe & ~statLoad & ~sepStrobe & repStrobe & ~legacy;
  end
endmodule

// File: rtl/owWidthMap.sv
module owWidthMap
  import owPkg::*;
#(
  parameter bit IS_INDEX = 1'b0
) (
  input  logic              tier16,
  input  logic              tier8,
  input  logic              narrowSel,
  output logic [CODE_W-1:0] code
);
  logic legacy;
  assign legacy = tier16 & tier8;

  generate
    if (IS_INDEX) begin : gIdx
      always_comb begin
        if (legacy || narrowSel) code = W8;
        else if (tier16)         code = W16;
        else                     code = W32;
      end
    end else begin : gAcc
      always_comb begin
        if (legacy || narrowSel)  code = W8;
        else if (tier8 && !tier16) code = W32;
        else                       code = W16;
      end
    end
  endgenerate
endmodule

// File: rtl/owDatapath.sv
module owDatapath
  import owPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  owStrobe_t         strobes,
  input  logic              cFlagIn,
  input  logic              vFlagIn,
  input  logic [1:0]        mxMask,
  input  logic [1:0]        statMx,
  output logic              legacy,
  output logic              flagM,
  output logic              flagX,
  output logic              cFlagOut,
  output logic              vFlagOut,
  output logic [CODE_W-1:0] accWidth,
  output logic [CODE_W-1:0] idxWidth,
  output logic [IMM_W-1:0]  immBytes
);
  logic tier16, tier8, mReg, xReg;
  logic next16, next8;

  assign legacy  = tier16 & tier8;
  assign next8   = cFlagIn;
  assign next16  = strobes.xchgV ? vFlagIn : tier16;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tier16 <= 1'b1;
      tier8  <= 1'b1;
      mReg   <= 1'b1;
      xReg   <= 1'b1;
    end else if (strobes.xchg) begin
      tier8  <= next8;
      tier16 <= next16;
      if (next8 && next16) begin
        mReg <= 1'b1;
        xReg <= 1'b1;
      end
    end else if (strobes.loadBits) begin
      mReg <= statMx[1] | legacy;
      xReg <= statMx[0] | legacy;
    end else if (strobes.setBits) begin
      mReg <= mReg | mxMask[1];
      xReg <= xReg | mxMask[0];
    end else if (strobes.clrBits) begin
      mReg <= mReg & ~mxMask[1];
      xReg <= xReg & ~mxMask[0];
    end
  end

  assign cFlagOut = strobes.xchg  ? tier8  : cFlagIn;
  assign vFlagOut = strobes.xchgV ? tier16 : vFlagIn;
  assign flagM    = mReg;
  assign flagX    = xReg;

  localparam int NCH = 2;
  logic [CODE_W-1:0] codes [NCH];
  logic              sels  [NCH];
  assign sels[0] = mReg;
  assign sels[1] = xReg;

  for (genvar g = 0; g < NCH; g++) begin : gMap
    owWidthMap #(.IS_INDEX(g == 1)) uMap (
      .tier16   (tier16),
      .tier8    (tier8),
      .narrowSel(sels[g]),
      .code     (codes[g])
    );
  end

  assign accWidth = codes[0];
  assign idxWidth = codes[1];
  assign immBytes = IMM_W'(1) << accWidth;
endmodule

// File: rtl/opWidthCtl.sv
module opWidthCtl
  import owPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xceStrobe,
  input  logic       cFlagIn,
  input  logic       vFlagIn,
  input  logic       sepStrobe,
  input  logic       repStrobe,
  input  logic [1:0] mxMask,
  input  logic       statLoad,
  input  logic [1:0] statMx,
  output logic [1:0] accWidth,
  output logic [1:0] idxWidth,
  output logic [2:0] immBytes,
  output logic       cFlagOut,
  output logic       vFlagOut,
  output logic       flagM,
  output logic       flagX,
  output logic       legacyMode
);
  owStrobe_t strobes;
  logic      legacy;

  owControl uCtl (
    .xceStrobe(xceStrobe),
    .statLoad (statLoad),
    .sepStrobe(sepStrobe),
    .repStrobe(repStrobe),
    .legacy   (legacy),
    .strobes  (strobes)
  );

  owDatapath uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cFlagIn (cFlagIn),
    .vFlagIn (vFlagIn),
    .mxMask  (mxMask),
    .statMx  (statMx),
    .legacy  (legacy),
    .flagM   (flagM),
    .flagX   (flagX),
    .cFlagOut(cFlagOut),
    .vFlagOut(vFlagOut),
    .accWidth(accWidth),
    .idxWidth(idxWidth),
    .immBytes(immBytes)
  );

  assign legacyMode = legacy;
endmodule

// File: rtl/opWidthCtlCheck.sv
module opWidthCtlCheck (
  input logic       clk,
  input logic       rstN,
  input logic       xceStrobe,
  input logic       cFlagIn,
  input logic       vFlagIn,
  input logic       sepStrobe,
  input logic       repStrobe,
  input logic       statLoad,
  input logic [1:0] accWidth,
  input logic [1:0] idxWidth,
  input logic       cFlagOut,
  input logic       vFlagOut,
  input logic       flagM,
  input logic       flagX,
  input logic       legacyMode
);
  AST_LEGACY_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    legacyMode |-> (accWidth == 2'b00 && idxWidth == 2'b00 && flagM && flagX)); // R2

  AST_LEGACY_XCHG: assert property (@(posedge clk) disable iff (!rstN)
    (xceStrobe && legacyMode) |-> (cFlagOut && vFlagOut == vFlagIn)); // R3

  AST_PASS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !xceStrobe |-> (cFlagOut == cFlagIn && vFlagOut == vFlagIn)); // R10

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!xceStrobe && !sepStrobe && !repStrobe && !statLoad) |=>
      ($stable(accWidth) && $stable(idxWidth) && $stable(legacyMode))); // R10

  AST_REP_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (repStrobe && !xceStrobe && !statLoad && !sepStrobe && legacyMode) |=>
      (flagM && flagX)); // R2

  AST_LEGACY_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (xceStrobe && !legacyMode && cFlagIn && vFlagIn) |=>
      (legacyMode && flagM && flagX)); // R11
endmodule

bind opWidthCtl opWidthCtlCheck uChk (
  .clk       (clk),
  .rstN      (rstN),
  .xceStrobe (xceStrobe),
  .cFlagIn   (cFlagIn),
  .vFlagIn   (vFlagIn),
  .sepStrobe (sepStrobe),
  .repStrobe (repStrobe),
  .statLoad  (statLoad),
  .accWidth  (accWidth),
  .idxWidth  (idxWidth),
  .cFlagOut  (cFlagOut),
  .vFlagOut  (vFlagOut),
  .flagM     (flagM),
  .flagX     (flagX),
  .legacyMode(legacyMode)
);

// File: tb/opWidthCtl_test.sv
module opWidthCtl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xceStrobe = 0, cFlagIn = 0, vFlagIn = 0;
  logic sepStrobe = 0, repStrobe = 0, statLoad = 0;
  logic [1:0] mxMask = 0, statMx = 0;
  logic [1:0] accWidth, idxWidth;
  logic [2:0] immBytes;
  logic cFlagOut, vFlagOut, flagM, flagX, legacyMode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  opWidthCtl uut (
    .clk(clk), .rstN(rstN), .xceStrobe(xceStrobe), .cFlagIn(cFlagIn),
    .vFlagIn(vFlagIn), .sepStrobe(sepStrobe), .repStrobe(repStrobe),
    .mxMask(mxMask), .statLoad(statLoad), .statMx(statMx),
    .accWidth(accWidth), .idxWidth(idxWidth), .immBytes(immBytes),
    .cFlagOut(cFlagOut), .vFlagOut(vFlagOut), .flagM(flagM),
    .flagX(flagX), .legacyMode(legacyMode)
  );

  typedef struct {
    logic [1:0] acc;
    logic [1:0] idx;
    logic [2:0] imm;
    logic       m;
    logic       x;
    logic       leg;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  // reference state kept by the bench
  logic mT16 = 1, mT8 = 1, mM = 1, mX = 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic expItem_t predict(input string tag);
    expItem_t it;
    logic leg;
    leg = mT16 & mT8;
    it.leg = leg;
    it.m = mM;
    it.x = mX;
    if (leg || mM) it.acc = 2'b00;
    else if (!mT16 && mT8) it.acc = 2'b10;
    else it.acc = 2'b01;
    if (leg || mX) it.idx = 2'b00;
    else if (mT16) it.idx = 2'b01;
    else it.idx = 2'b10;
    it.imm = (it.acc == 2'b00) ? 3'd1 : (it.acc == 2'b01) ? 3'd2 : 3'd4;
    it.tag = tag;
    return it;
  endfunction

  task automatic clearIn();
    xceStrobe = 0; sepStrobe = 0; repStrobe = 0; statLoad = 0;
  endtask

  // exchange: checks the traded flags before the edge, queues the new state
  task automatic doXce(input logic c, input logic v, input string tag);
    logic expC, expV, leg;
    @(negedge clk);
    clearIn();
    xceStrobe = 1; cFlagIn = c; vFlagIn = v;
    leg = mT16 & mT8;
    expC = mT8;
    expV = leg ? v : mT16;
    #1;
    check(cFlagOut == expC, tag, "cFlagOut", int'(cFlagOut), int'(expC));
    check(vFlagOut == expV, tag, "vFlagOut", int'(vFlagOut), int'(expV));
    mT8 = c;
    if (!leg) mT16 = v;
    if (mT16 && mT8) begin mM = 1; mX = 1; end
    expQ.push_back(predict(tag));
  endtask

  task automatic doMx(input logic s, input logic r, input logic [1:0] mask,
                      input string tag);
    logic leg;
    @(negedge clk);
    clearIn();
    sepStrobe = s; repStrobe = r; mxMask = mask;
    leg = mT16 & mT8;
    if (s) begin mM = mM | mask[1]; mX = mX | mask[0]; end
    else if (r && !leg) begin mM = mM & ~mask[1]; mX = mX & ~mask[0]; end
    expQ.push_back(predict(tag));
  endtask

  task automatic doLoad(input logic [1:0] val, input string tag);
    logic leg;
    @(negedge clk);
    clearIn();
    statLoad = 1; statMx = val;
    leg = mT16 & mT8;
    mM = val[1] | leg;
    mX = val[0] | leg;
    expQ.push_back(predict(tag));
  endtask

  task automatic doIdle(input logic c, input logic v, input string tag);
    @(negedge clk);
    clearIn();
    cFlagIn = c; vFlagIn = v;
    #1;
    check(cFlagOut == c, tag, "pass cFlagOut", int'(cFlagOut), int'(c));
    check(vFlagOut == v, tag, "pass vFlagOut", int'(vFlagOut), int'(v));
    expQ.push_back(predict(tag));
  endtask

  // monitor: compares registered outputs after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN && expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(accWidth == it.acc, it.tag, "accWidth", int'(accWidth), int'(it.acc));
        check(idxWidth == it.idx, it.tag, "idxWidth", int'(idxWidth), int'(it.idx));
        check(immBytes == it.imm, it.tag, "immBytes", int'(immBytes), int'(it.imm));
        check(flagM == it.m, it.tag, "flagM", int'(flagM), int'(it.m));
        check(flagX == it.x, it.tag, "flagX", int'(flagX), int'(it.x));
        check(legacyMode == it.leg, it.tag, "legacyMode", int'(legacyMode), int'(it.leg));
      end
    end
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(accWidth == 2'b00, "R1", "accWidth", int'(accWidth), 0);
    check(idxWidth == 2'b00, "R1", "idxWidth", int'(idxWidth), 0);
    check(immBytes == 3'd1, "R1", "immBytes", int'(immBytes), 1);
    check(legacyMode && flagM && flagX, "R1", "legacy/M/X", int'({legacyMode, flagM, flagX}), 7);

    doMx(0, 1, 2'b11, "R2");       // clear blocked in legacy
    doLoad(2'b00, "R2");           // load of zeros blocked in legacy
    doXce(0, 0, "R3");             // enter 16-bit tier, V passes through
    doIdle(1, 0, "R12");           // legacyMode now 0
    doMx(0, 1, 2'b11, "R5");       // acc16 idx16
    doMx(1, 0, 2'b10, "R5");       // acc8 idx16
    doXce(0, 0, "R4");             // to tier16=0 tier8=0
    doMx(0, 1, 2'b10, "R6");       // acc16 idx32
    doMx(1, 0, 2'b01, "R6");       // idx8
    doMx(0, 1, 2'b01, "R6");
    doXce(1, 0, "R4");             // to tier16=0 tier8=1
    doIdle(0, 1, "R8");            // acc32 imm4
    doMx(1, 0, 2'b01, "R7");       // idx8
    doLoad(2'b10, "R9");           // M=1 X=0
    doMx(0, 1, 2'b10, "R9");       // tier kept: acc32 again
    doMx(1, 1, 2'b10, "R13");      // set wins over clear
    doIdle(1, 1, "R10");
    doXce(0, 1, "R4");             // back to 16-bit tier
    doMx(0, 1, 2'b11, "R5");       // acc16 idx16
    doXce(1, 1, "R11");            // into legacy, M/X forced
    doXce(1, 0, "R3");             // stays legacy, only carry traded
    doIdle(0, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    if (expQ.size() != 0) check(0, "R10", "queue drained", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule